// File: doc/BRIEF.md
# Dual-Channel Disk Interface Register Decoder

This block is the host-facing register decoder of a two-channel ATA-style disk card. A byte-wide host bus presents an address and separate read and write strobes. The block decodes each access into one of several targets. These are a taskfile window and a control/alternate-status register for each channel, a per-channel interrupt gate and interrupt status byte, a select latch, and a card identity code that is spread across four bytes. Taskfile and control accesses pass to the drive side only as a per-channel chip select and a three-bit register index. Read data for those accesses comes back on a shared drive data input.

Each drive raises its own interrupt line. A write to a channel's interrupt gate address arms that channel, and a read of the same address disarms it. The block's single interrupt output is raised while any armed channel has its drive interrupt pending. The select latch serves two purposes. One of its bits opens the extended region that holds the taskfile and control registers. Another bit steers the card's single DMA request/acknowledge pair to one of the two channels.

Top module: `twin_disk_regdec`

## Requirements
- R1: With latch bit 5 set, an access of either strobe at channel base + (n << 6) asserts only that channel's `drv_cs` bit and drives `drv_reg` = n. The channel bases are 0x2000 for channel 0 and 0x3000 for channel 1, and n runs from 0 to 7. A read there returns `drv_rdata`.
- R2: With latch bit 5 set, an access at 0x2380 (channel 0) or 0x3380 (channel 1) asserts only that channel's `drv_ctl_cs` bit with `drv_reg` = 6. A read there returns `drv_rdata`.
- R3: Any host write to 0x2200 (channel 0) or 0x3200 (channel 1) arms that channel's interrupt from the next clock, whatever the data.
- R4: A host read of the same gate address, with no write in that cycle, disarms the channel from the next clock. Its read data carries no meaning.
- R5: `irq_out` is high exactly when some channel is both armed and has `drv_irq` high. After reset both channels are disarmed.
- R6: A read of 0x2290 (channel 0) or 0x3290 (channel 1) returns the channel's `drv_irq` level in bit 0 and zeros elsewhere. The value does not depend on the armed state.
- R7: The byte at 0x2280 + 4k (k = 0..3) reads identity bit k in bit 0 and zeros elsewhere. The identity value is 3, so bits 0 and 1 read 1 and bits 2 and 3 read 0.
- R8: A write to address 0 loads the select latch, which resets to 0. While latch bit 5 is clear, taskfile and control accesses assert no chip select and read 0xFF.
- R9: Latch bit 0 picks the DMA channel (0 or 1). `host_dmarq` follows that channel's `drv_dmarq`, and `host_dmack` reaches only that channel's `drv_dmack` bit.
- R10: Any other address, including near misses beside the taskfile slots, asserts no chip select and reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 14 | Host byte address |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid during the read strobe |
| drv_rdata | input | 8 | Read data returned from the selected drive register |
| drv_irq | input | 2 | Drive interrupt request per channel |
| irq_out | output | 1 | Combined card interrupt |
| drv_cs | output | 2 | Taskfile chip select per channel |
| drv_ctl_cs | output | 2 | Control/alternate-status chip select per channel |
| drv_reg | output | 3 | Drive register index |
| drv_dmarq | input | 2 | DMA request from each channel |
| host_dmarq | output | 1 | DMA request routed to the host |
| host_dmack | input | 1 | DMA acknowledge from the host |
| drv_dmack | output | 2 | DMA acknowledge routed to the chosen channel |

## Verification
The assertions assume that the host raises at most one strobe in a cycle, and that address and data stay steady while a strobe is high. They also assume that a read of a gate address carries no write. The bench drives every access from a task that sets the address, data and one strobe together on a falling edge, and drops the strobe just after the next rising edge. As a result, each access covers exactly one active edge. The drive-side interrupt, request and data inputs change only between accesses.

// File: rtl/twin_disk_regdec.sv
module twin_disk_regdec #(
  parameter int          AW      = 14,
  parameter logic [3:0]  CARD_ID = 4'd3,
  parameter int          STEP    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] host_addr,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  input  logic [7:0]    drv_rdata,
  input  logic [1:0]    drv_irq,
  output logic          irq_out,
  output logic [1:0]    drv_cs,
  output logic [1:0]    drv_ctl_cs,
  output logic [2:0]    drv_reg,
  input  logic [1:0]    drv_dmarq,
  output logic          host_dmarq,
  input  logic          host_dmack,
  output logic [1:0]    drv_dmack
);

  localparam int          LW        = AW - 2;
  localparam logic [LW-1:0] OFS_GATE = LW'(12'h200);
  localparam logic [LW-1:0] OFS_STAT = LW'(12'h290);
  localparam logic [LW-1:0] OFS_CTL  = LW'(12'h380);
  localparam logic [LW-1:0] OFS_ID   = LW'(12'h280);

  logic [7:0] sel_q;
  logic [1:0] armed_q;
  logic       acc, ext_en;
  logic [LW-1:0] low;
  logic [1:0] in_ch, tf_hit, ctl_hit, gate_hit, stat_hit;
  logic       id_hit, latch_hit;

  assign acc    = host_rd | host_wr;
  assign low    = host_addr[LW-1:0];
  assign ext_en = sel_q[5];

  assign in_ch[0] = host_addr[AW-1:AW-2] == 2'b10;
  assign in_ch[1] = host_addr[AW-1:AW-2] == 2'b11;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    assign tf_hit[c]   = in_ch[c] && (low >> (STEP + 3)) == '0 && low[STEP-1:0] == '0;
    assign ctl_hit[c]  = in_ch[c] && low == OFS_CTL;
    assign gate_hit[c] = in_ch[c] && low == OFS_GATE;
    assign stat_hit[c] = in_ch[c] && low == OFS_STAT;

    always_ff @(posedge clk) begin
      if (!rst_n)                       armed_q[c] <= 1'b0;
      else if (host_wr && gate_hit[c])  armed_q[c] <= 1'b1;
      else if (host_rd && gate_hit[c])  armed_q[c] <= 1'b0;
    end

    assign drv_cs[c]     = acc && ext_en && tf_hit[c];
    assign drv_ctl_cs[c] = acc && ext_en && ctl_hit[c];
    assign drv_dmack[c]  = host_dmack && (sel_q[0] == 1'(c));
  end

  assign id_hit    = in_ch[0] && (low >> 4) == (OFS_ID >> 4) && low[1:0] == 2'b00;
  assign latch_hit = host_addr == '0;

  always_ff @(posedge clk) begin
    if (!rst_n)                    sel_q <= 8'h00;
    else if (host_wr && latch_hit) sel_q <= host_wdata;
  end

  assign drv_reg    = (|drv_cs || |drv_ctl_cs) ? host_addr[STEP+2:STEP] : 3'd0;
  assign irq_out    = |(drv_irq & armed_q);
  assign host_dmarq = drv_dmarq[sel_q[0]];

  always_comb begin
    host_rdata = 8'hFF;
    if (host_rd) begin
      if (|drv_cs || |drv_ctl_cs) host_rdata = drv_rdata;
      else if (stat_hit[0])       host_rdata = {7'd0, drv_irq[0]};
      else if (stat_hit[1])       host_rdata = {7'd0, drv_irq[1]};
      else if (id_hit)            host_rdata = {7'd0, CARD_ID[low[3:2]]};
    end
  end

endmodule

// File: rtl/twin_disk_regdec_chk.sv
module twin_disk_regdec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [13:0] host_addr,
  input logic        host_rd,
  input logic        host_wr,
  input logic [7:0]  host_wdata,
  input logic [7:0]  host_rdata,
  input logic [1:0]  drv_irq,
  input logic        irq_out,
  input logic [1:0]  drv_cs,
  input logic [1:0]  drv_ctl_cs,
  input logic        host_dmack,
  input logic [1:0]  drv_dmack
);

  a_r1_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drv_cs, drv_ctl_cs}));

  a_r3_arm_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $past(host_wr && host_addr == 14'h2200) && drv_irq[0] |-> irq_out);

  a_r4_disarm_quiets_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $past(host_rd && !host_wr && host_addr == 14'h2200) && !drv_irq[1] |-> !irq_out);

  a_r6_status_bit: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && host_addr == 14'h3290 |-> host_rdata == {7'd0, drv_irq[1]});

  a_r8_closed_window: assert property (@(posedge clk) disable iff (!rst_n)
    $past(host_wr && host_addr == 14'h0000 && !host_wdata[5]) |-> drv_cs == 2'b00 && drv_ctl_cs == 2'b00);

  a_r9_one_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drv_dmack) && (!host_dmack -> drv_dmack == 2'b00));

endmodule

bind twin_disk_regdec twin_disk_regdec_chk chk_i (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
  .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
  .drv_irq(drv_irq), .irq_out(irq_out), .drv_cs(drv_cs),
  .drv_ctl_cs(drv_ctl_cs), .host_dmack(host_dmack), .drv_dmack(drv_dmack)
);

// File: tb/twin_disk_regdec_tb_top.sv
`timescale 1ns/1ps
module twin_disk_regdec_tb_top;
  logic clk = 0, rst_n = 0;
  logic [13:0] host_addr = '0;
  logic host_rd = 0, host_wr = 0;
  logic [7:0] host_wdata = '0, host_rdata, drv_rdata = '0;
  logic [1:0] drv_irq = '0, drv_cs, drv_ctl_cs, drv_dmarq = '0, drv_dmack;
  logic irq_out, host_dmarq, host_dmack = 0;
  logic [2:0] drv_reg;
  int checks = 0, errors = 0;
  logic [7:0] s_rdata; logic [1:0] s_cs, s_ctl; logic [2:0] s_reg;

  always #2.5 clk = ~clk;

  twin_disk_regdec dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic acc(input logic [13:0] a, input bit r, input bit w, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_rd = r; host_wr = w; host_wdata = d;
    #1; s_rdata = host_rdata; s_cs = drv_cs; s_ctl = drv_ctl_cs; s_reg = drv_reg;
    @(posedge clk); #1; host_rd = 0; host_wr = 0;
  endtask

  task automatic closed_sweep(input string req);
    for (int c = 0; c < 2; c++) begin
      for (int n = 0; n < 9; n++) begin
        logic [13:0] a;
        a = (n < 8) ? 14'(14'h2000 + c*14'h1000 + (n << 6)) : 14'(14'h2380 + c*14'h1000);
        drv_rdata = 8'h5A;
        acc(a, 1, 0, 0);
        chk(s_rdata == 8'hFF && s_cs == 0 && s_ctl == 0, req, {s_rdata, s_cs, s_ctl}, 12'hFF0);
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R5 reset: pending inputs, both disarmed
    drv_irq = 2'b11; #1;
    chk(irq_out == 0, "R5 reset disarmed", irq_out, 0);
    drv_irq = 2'b00;
    // R8 reset latch closed
    closed_sweep("R8 window closed after reset");
    // R7 identity bit order
    begin
      logic [3:0] id;
      for (int k = 0; k < 4; k++) begin
        acc(14'(14'h2280 + 4*k), 1, 0, 0);
        chk(s_rdata[7:1] == 0, "R7 identity upper bits", s_rdata, {7'd0, s_rdata[0]});
        id[k] = s_rdata[0];
      end
      chk(id == 4'd3, "R7 identity value", id, 3);
    end
    // R8 open window
    acc(14'h0000, 0, 1, 8'h20);
    // R1 taskfile sweep, both strobes
    for (int c = 0; c < 2; c++)
      for (int n = 0; n < 8; n++)
        for (int w = 0; w < 2; w++) begin
          drv_rdata = 8'(c*16 + n + 8'h40);
          acc(14'(14'h2000 + c*14'h1000 + (n << 6)), !w, w, 8'h11);
          chk(s_cs == 2'(1 << c) && s_ctl == 0 && s_reg == 3'(n), "R1 taskfile select",
              {s_cs, s_ctl, s_reg}, {2'(1 << c), 2'b00, 3'(n)});
          if (!w) chk(s_rdata == 8'(c*16 + n + 8'h40), "R1 taskfile read data", s_rdata, c*16 + n + 8'h40);
        end
    // R2 control registers
    for (int c = 0; c < 2; c++) begin
      drv_rdata = 8'(8'hA0 + c);
      acc(14'(14'h2380 + c*14'h1000), 1, 0, 0);
      chk(s_ctl == 2'(1 << c) && s_cs == 0 && s_reg == 3'd6 && s_rdata == 8'(8'hA0 + c),
          "R2 control select", {s_ctl, s_cs, s_reg, s_rdata}, {2'(1 << c), 2'b00, 3'd6, 8'(8'hA0 + c)});
    end
    // R10 near misses and unmapped addresses
    begin
      logic [13:0] miss [6] = '{14'h2004, 14'h2020, 14'h2200 - 14'h40 + 14'h20, 14'h2400, 14'h1000, 14'h3284};
      for (int i = 0; i < 6; i++) begin
        acc(miss[i], 1, 0, 0);
        chk(s_rdata == 8'hFF && s_cs == 0 && s_ctl == 0, "R10 unmapped", {s_rdata, s_cs, s_ctl}, 12'hFF0);
      end
    end
    // R6 status independent of arm state
    for (int p = 0; p < 4; p++) begin
      drv_irq = 2'(p);
      for (int c = 0; c < 2; c++) begin
        acc(14'(14'h2290 + c*14'h1000), 1, 0, 0);
        chk(s_rdata == {7'd0, drv_irq[c]}, "R6 status bit", s_rdata, drv_irq[c]);
      end
    end
    // R3 R4 R5 arm/disarm over all arm and pending patterns
    for (int a = 0; a < 4; a++)
      for (int p = 0; p < 4; p++) begin
        drv_irq = 2'b11;
        acc(14'h2200, 1, 0, 0);
        acc(14'h3200, 1, 0, 0);
        @(negedge clk);
        chk(irq_out == 0, "R4 disarm by read", irq_out, 0);
        if (a[0]) acc(14'h2200, 0, 1, 8'(a*17));
        if (a[1]) acc(14'h3200, 0, 1, 8'h00);
        drv_irq = 2'(p);
        @(negedge clk);
        chk(irq_out == |(2'(a) & 2'(p)), "R3 R5 armed interrupt", irq_out, |(2'(a) & 2'(p)));
      end
    // R9 DMA routing
    for (int s = 0; s < 2; s++) begin
      acc(14'h0000, 0, 1, 8'(8'h20 | s));
      for (int q = 0; q < 4; q++)
        for (int k = 0; k < 2; k++) begin
          drv_dmarq = 2'(q); host_dmack = k[0];
          @(negedge clk);
          chk(host_dmarq == drv_dmarq[s], "R9 request route", host_dmarq, drv_dmarq[s]);
          chk(drv_dmack == (k[0] ? 2'(1 << s) : 2'b00), "R9 ack route", drv_dmack, k[0] ? (1 << s) : 0);
        end
    end
    host_dmack = 0;
    // R8 writing zero closes the window again
    acc(14'h0000, 0, 1, 8'h00);
    closed_sweep("R8 window closed by zero write");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule